// File: doc/BRIEF.md
# Single-Cycle Add-Immediate Datapath

This block is the smallest useful slice of a single-cycle processor. On every clock it takes the 32-bit instruction word that instruction memory returns for the current program counter. It pulls out the source and destination register numbers and the 12-bit immediate. It reads the source register, widens the immediate to 32 bits with its sign, and adds the two. At the end of the cycle it writes the sum back into the destination register.

Control is hard-wired for the add-immediate instruction alone. The adder is always selected, the register write is always enabled, and the second adder operand is always the immediate. The opcode and function fields are never examined, so every word is executed as an add-immediate. The program counter is a byte address that moves forward one word per clock. The block also gives the word index that addresses instruction memory. The data-memory side is present only as outputs held at zero. Eight architectural registers are brought out for observation.

Top module: `sc_addi_core`

## Requirements
- R1: While rst_ni is low, the program counter reads 0 and all 31 writable registers read 0. The observed registers are x1, x2 and x5 to x10.
- R2: After reset is released, the program counter rises by 4 on every rising clock edge and wraps modulo 2^32.
- R3: The instruction memory word index equals the program counter with its two low bits dropped, truncated to IMEM_AW bits (14 by default).
- R4: At a rising edge, register rd (instruction bits [11:7]) takes the value of register rs1 (bits [19:15]) plus the immediate (bits [31:20]). All other registers keep their values.
- R5: The immediate is sign-extended from instruction bit 31. 0x7FF adds 2047, 0x800 adds -2048 and 0xFFF adds -1.
- R6: A write whose destination is register 0 is discarded, and register 0 always reads as 0 when used as a source.
- R7: The opcode field (bits [6:0]) and the function field (bits [14:12]) have no effect on the result. An instruction with any values in these fields executes as an add-immediate.
- R8: The sum wraps modulo 2^32 with no overflow indication.
- R9: The data-memory address, write data and 4-bit write mask outputs are always 0.
- R10: The observation outputs show x1, x2, x5, x6, x7, x8, x9 and x10. A write to any other register leaves all eight unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word at the current program counter |
| pc_o | output | 32 | Program counter, byte address |
| imem_idx_o | output | 14 | Instruction memory word index |
| dmem_addr_o | output | 32 | Data memory address, held at 0 |
| dmem_wdata_o | output | 32 | Data memory write data, held at 0 |
| dmem_wmask_o | output | 4 | Data memory byte write mask, held at 0 |
| dbg_x1_o | output | 32 | Register x1 |
| dbg_x2_o | output | 32 | Register x2 |
| dbg_x5_o | output | 32 | Register x5 |
| dbg_x6_o | output | 32 | Register x6 |
| dbg_x7_o | output | 32 | Register x7 |
| dbg_x8_o | output | 32 | Register x8 |
| dbg_x9_o | output | 32 | Register x9 |
| dbg_x10_o | output | 32 | Register x10 |

## Verification
The hardest case to reach from the ports is a register that has no observation output, such as x3, x4 or x31. Its contents can only be seen by running a second instruction that adds zero to it and writes the result into an observed register. The bench therefore writes the hidden register first and checks that none of the eight observed outputs moved. It then copies the hidden register into x10 and compares x10 with its own register model. Register 0 is tested the same way: a write to it is attempted, and register 0 is then read back through x10.

// File: rtl/sc_addi_pkg.sv
package sc_addi_pkg;
  localparam int unsigned XLEN     = 32;
  localparam int unsigned REG_AW   = 5;
  localparam int unsigned NREG     = 1 << REG_AW;
  localparam int unsigned IMM_W    = 12;
  localparam int unsigned PC_STEP  = 4;
  localparam int unsigned WMASK_W  = XLEN / 8;

  typedef logic [XLEN-1:0]   word_t;
  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef enum logic [3:0] {
    ALU_ADD = 4'b0000
  } alu_sel_e;

  // I-type field layout, bit 31 first
  typedef struct packed {
    logic [IMM_W-1:0] imm;
    reg_idx_t         rs1;
    logic [2:0]       funct3;
    reg_idx_t         rd;
    logic [6:0]       opcode;
  } itype_t;
endpackage

// File: rtl/sc_addi_pc.sv
module sc_addi_pc
  import sc_addi_pkg::*;
#(
  parameter int unsigned IMEM_AW = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  output word_t              pc_o,
  output logic [IMEM_AW-1:0] imem_idx_o
);
  localparam int unsigned IDX_LSB = $clog2(PC_STEP);

  word_t pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_q + word_t'(PC_STEP);
  end

  assign pc_o       = pc_q;
  assign imem_idx_o = pc_q[IMEM_AW+IDX_LSB-1:IDX_LSB];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc_q[XLEN-1:IMEM_AW+IDX_LSB], pc_q[IDX_LSB-1:0]};
endmodule

// File: rtl/sc_addi_decode.sv
module sc_addi_decode
  import sc_addi_pkg::*;
(
  input  word_t    instr_i,
  output reg_idx_t rs1_o,
  output reg_idx_t rd_o,
  output word_t    imm_o
);
  itype_t f;
  assign f     = itype_t'(instr_i);
  assign rs1_o = f.rs1;
  assign rd_o  = f.rd;
  assign imm_o = {{(XLEN-IMM_W){f.imm[IMM_W-1]}}, f.imm};

  // opcode and funct3 are not decoded: control is fixed
  logic unused_fields;
  assign unused_fields = ^{f.opcode, f.funct3};
endmodule

// File: rtl/sc_addi_regfile.sv
module sc_addi_regfile
  import sc_addi_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  reg_idx_t rs1_i,
  input  reg_idx_t rd_i,
  input  logic     we_i,
  input  word_t    wdata_i,
  output word_t    rdata1_o,
  output word_t    dbg_x1_o,
  output word_t    dbg_x2_o,
  output word_t    dbg_x5_o,
  output word_t    dbg_x6_o,
  output word_t    dbg_x7_o,
  output word_t    dbg_x8_o,
  output word_t    dbg_x9_o,
  output word_t    dbg_x10_o
);
  word_t regs_q [NREG];

  assign regs_q[0] = '0;

  for (genvar i = 1; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          regs_q[i] <= '0;
      else if (we_i && rd_i == reg_idx_t'(i)) regs_q[i] <= wdata_i;
    end
  end

  assign rdata1_o  = regs_q[rs1_i];
  assign dbg_x1_o  = regs_q[1];
  assign dbg_x2_o  = regs_q[2];
  assign dbg_x5_o  = regs_q[5];
  assign dbg_x6_o  = regs_q[6];
  assign dbg_x7_o  = regs_q[7];
  assign dbg_x8_o  = regs_q[8];
  assign dbg_x9_o  = regs_q[9];
  assign dbg_x10_o = regs_q[10];
endmodule

// File: rtl/sc_addi_alu.sv
module sc_addi_alu
  import sc_addi_pkg::*;
(
  input  word_t    a_i,
  input  word_t    b_i,
  input  alu_sel_e sel_i,
  output word_t    res_o
);
  always_comb begin
    unique case (sel_i)
      ALU_ADD: res_o = a_i + b_i;
      default: res_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/sc_addi_core.sv
module sc_addi_core
  import sc_addi_pkg::*;
#(
  parameter int unsigned IMEM_AW = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        instr_i,
  output logic [31:0]        pc_o,
  output logic [IMEM_AW-1:0] imem_idx_o,
  output logic [31:0]        dmem_addr_o,
  output logic [31:0]        dmem_wdata_o,
  output logic [3:0]         dmem_wmask_o,
  output logic [31:0]        dbg_x1_o,
  output logic [31:0]        dbg_x2_o,
  output logic [31:0]        dbg_x5_o,
  output logic [31:0]        dbg_x6_o,
  output logic [31:0]        dbg_x7_o,
  output logic [31:0]        dbg_x8_o,
  output logic [31:0]        dbg_x9_o,
  output logic [31:0]        dbg_x10_o
);
  reg_idx_t rs1_idx, rd_idx;
  word_t    imm_ext, rs1_data, alu_res;

  // fixed control for the single supported instruction
  localparam alu_sel_e ALU_SEL = ALU_ADD;
  localparam logic     REG_WE  = 1'b1;

  sc_addi_pc #(.IMEM_AW(IMEM_AW)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pc_o       (pc_o),
    .imem_idx_o (imem_idx_o)
  );

  sc_addi_decode u_dec (
    .instr_i (instr_i),
    .rs1_o   (rs1_idx),
    .rd_o    (rd_idx),
    .imm_o   (imm_ext)
  );

  sc_addi_regfile u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rs1_i     (rs1_idx),
    .rd_i      (rd_idx),
    .we_i      (REG_WE),
    .wdata_i   (alu_res),
    .rdata1_o  (rs1_data),
    .dbg_x1_o  (dbg_x1_o),
    .dbg_x2_o  (dbg_x2_o),
    .dbg_x5_o  (dbg_x5_o),
    .dbg_x6_o  (dbg_x6_o),
    .dbg_x7_o  (dbg_x7_o),
    .dbg_x8_o  (dbg_x8_o),
    .dbg_x9_o  (dbg_x9_o),
    .dbg_x10_o (dbg_x10_o)
  );

  sc_addi_alu u_alu (
    .a_i   (rs1_data),
    .b_i   (imm_ext),
    .sel_i (ALU_SEL),
    .res_o (alu_res)
  );

  assign dmem_addr_o  = '0;
  assign dmem_wdata_o = '0;
  assign dmem_wmask_o = '0;
endmodule

// File: rtl/sc_addi_core_chk.sv
module sc_addi_core_chk #(
  parameter int unsigned IMEM_AW = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [31:0]        instr_i,
  input logic [31:0]        pc_o,
  input logic [IMEM_AW-1:0] imem_idx_o,
  input logic [31:0]        dmem_addr_o,
  input logic [31:0]        dmem_wdata_o,
  input logic [3:0]         dmem_wmask_o,
  input logic [31:0]        dbg_x1_o,
  input logic [31:0]        rs1_data,
  input logic [31:0]        imm_ext
);
  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pc_o == $past(pc_o) + 32'd4);  // R2

  AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> imem_idx_o == $past(imem_idx_o) + 1'b1);  // R3

  AST_DMEM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dmem_addr_o == '0 && dmem_wdata_o == '0 && dmem_wmask_o == '0);  // R9

  AST_X1_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[11:7] == 5'd1 |=> dbg_x1_o == $past(rs1_data + imm_ext));  // R4

  AST_X1_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[11:7] != 5'd1 |=> $stable(dbg_x1_o));  // R10

  AST_IMM_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imm_ext[31:11] == {21{instr_i[31]}});  // R5
endmodule

bind sc_addi_core sc_addi_core_chk #(.IMEM_AW(IMEM_AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .instr_i      (instr_i),
  .pc_o         (pc_o),
  .imem_idx_o   (imem_idx_o),
  .dmem_addr_o  (dmem_addr_o),
  .dmem_wdata_o (dmem_wdata_o),
  .dmem_wmask_o (dmem_wmask_o),
  .dbg_x1_o     (dbg_x1_o),
  .rs1_data     (rs1_data),
  .imm_ext      (imm_ext)
);

// File: tb/sc_addi_core_bench.sv
`timescale 1ns/1ps
module sc_addi_core_bench;
  localparam int unsigned IMEM_AW = 14;
  localparam int unsigned WATCHDOG_CYC = 20000;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] pc_o, dmem_addr_o, dmem_wdata_o;
  logic [IMEM_AW-1:0] imem_idx_o;
  logic [3:0] dmem_wmask_o;
  logic [31:0] dbg_x1_o, dbg_x2_o, dbg_x5_o, dbg_x6_o, dbg_x7_o, dbg_x8_o, dbg_x9_o, dbg_x10_o;

  always #2.5 clk_i = ~clk_i;

  sc_addi_core #(.IMEM_AW(IMEM_AW)) u_sc_addi_core (
    .clk_i, .rst_ni, .instr_i, .pc_o, .imem_idx_o,
    .dmem_addr_o, .dmem_wdata_o, .dmem_wmask_o,
    .dbg_x1_o, .dbg_x2_o, .dbg_x5_o, .dbg_x6_o,
    .dbg_x7_o, .dbg_x8_o, .dbg_x9_o, .dbg_x10_o
  );

  int n_checks = 0;
  int n_errors = 0;
  logic [31:0] model [32];
  logic [31:0] exp_pc;

  function automatic logic [31:0] enc(input logic [11:0] imm, input logic [4:0] rs1,
                                      input logic [4:0] rd, input logic [2:0] f3,
                                      input logic [6:0] op);
    return {imm, rs1, f3, rd, op};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    check(req, "x1",  dbg_x1_o,  model[1]);
    check(req, "x2",  dbg_x2_o,  model[2]);
    check(req, "x5",  dbg_x5_o,  model[5]);
    check(req, "x6",  dbg_x6_o,  model[6]);
    check(req, "x7",  dbg_x7_o,  model[7]);
    check(req, "x8",  dbg_x8_o,  model[8]);
    check(req, "x9",  dbg_x9_o,  model[9]);
    check(req, "x10", dbg_x10_o, model[10]);
  endtask

  // drive at negedge, commit at posedge, observe at next negedge
  task automatic exec(input logic [31:0] word, input string req);
    logic [4:0] rs1, rd;
    logic [31:0] imm;
    rs1 = word[19:15];
    rd  = word[11:7];
    imm = {{20{word[31]}}, word[31:20]};
    instr_i = word;
    @(posedge clk_i);
    @(negedge clk_i);
    if (rd != 5'd0) model[rd] = model[rs1] + imm;
    exp_pc = exp_pc + 32'd4;
    check_state(req);
    check("R2", "pc", pc_o, exp_pc);
    check("R3", "imem_idx", {18'd0, imem_idx_o}, {18'd0, exp_pc[IMEM_AW+1:2]});
    check("R9", "dmem", {dmem_addr_o | dmem_wdata_o, 28'd0, dmem_wmask_o}, '0);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 32; i++) model[i] = '0;
    exp_pc = '0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1", "pc in reset", pc_o, 32'd0);
    check_state("R1");
    rst_ni = 1'b1;
    check("R1", "pc after release", pc_o, 32'd0);
  endtask

  task automatic t_basic;
    exec(enc(12'd5, 5'd0, 5'd1, 3'd0, 7'h13), "R4");
    exec(enc(12'd100, 5'd1, 5'd2, 3'd0, 7'h13), "R4");
    exec(enc(12'hFFD, 5'd2, 5'd5, 3'd0, 7'h13), "R4");
    exec(enc(12'd7, 5'd5, 5'd5, 3'd0, 7'h13), "R4");
  endtask

  task automatic t_sign;
    exec(enc(12'h7FF, 5'd0, 5'd6, 3'd0, 7'h13), "R5");
    exec(enc(12'h800, 5'd0, 5'd7, 3'd0, 7'h13), "R5");
    exec(enc(12'hFFF, 5'd6, 5'd8, 3'd0, 7'h13), "R5");
    check("R5", "x7 = -2048", dbg_x7_o, 32'hFFFF_F800);
  endtask

  task automatic t_x0;
    exec(enc(12'd123, 5'd1, 5'd0, 3'd0, 7'h13), "R6");
    exec(enc(12'd0, 5'd0, 5'd10, 3'd0, 7'h13), "R6");
    check("R6", "x0 readback", dbg_x10_o, 32'd0);
  endtask

  task automatic t_ignore;
    exec(enc(12'd9, 5'd1, 5'd9, 3'd7, 7'h33), "R7");
    exec(enc(12'd1, 5'd9, 5'd9, 3'd2, 7'h00), "R7");
    check("R7", "x9 = x1+10", dbg_x9_o, 32'd15);
  endtask

  task automatic t_wrap;
    exec(enc(12'hFFF, 5'd0, 5'd8, 3'd0, 7'h13), "R8");
    exec(enc(12'd1, 5'd8, 5'd8, 3'd0, 7'h13), "R8");
    check("R8", "wrap to 0", dbg_x8_o, 32'd0);
  endtask

  task automatic t_hidden;
    exec(enc(12'd42, 5'd1, 5'd3, 3'd0, 7'h13), "R10");
    exec(enc(12'h800, 5'd3, 5'd31, 3'd0, 7'h13), "R10");
    exec(enc(12'd0, 5'd3, 5'd10, 3'd0, 7'h13), "R10");
    check("R10", "x10 = x3", dbg_x10_o, 32'd47);
    exec(enc(12'd0, 5'd31, 5'd10, 3'd0, 7'h13), "R10");
    check("R10", "x10 = x31", dbg_x10_o, 32'd47 - 32'd2048);
  endtask

  task automatic t_reset_again;
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check("R1", "async pc clear", pc_o, 32'd0);
    for (int i = 0; i < 32; i++) model[i] = '0;
    check_state("R1");
    exp_pc = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    exec(enc(12'd3, 5'd0, 5'd1, 3'd0, 7'h13), "R4");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_sign();
    t_x0();
    t_ignore();
    t_wrap();
    t_hidden();
    t_reset_again();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk_i);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule